// File: doc/BRIEF.md
# UART Event Register with Break and Busy Tracking

This block gathers the status strobes of one UART channel into an 8-bit event register and raises an interrupt request. A separate receiver and transmitter supply one-cycle strobes: character complete, all-zeros flag, idle bit sampled, stop-bit midpoint, a receive-buffer-available level, last transmit character placed in the FIFO, and receive buffer closed. Software reads the event register and a mask register over a small register bus. It clears events by writing ones.

Two small state machines derive the stateful events. The break tracker has states `BRK_QUIET` and `BRK_IN_BREAK`. The transition BREAK_START (QUIET to IN_BREAK) fires on a completed all-zeros character and sets the break-received bit. The transition BREAK_END (IN_BREAK to QUIET) fires on the next idle bit and sets the break-end bit. The busy tracker has states `BSY_ACCEPT` and `BSY_STALLED`. The transition DROP (ACCEPT to STALLED) fires at a stop-bit midpoint when no buffer is available and sets the busy bit. The transition RESUME (STALLED to ACCEPT) fires once a buffer becomes available.

Top module: `uart_evt_top`

## Requirements
- R1: Register bits are numbered with bit 0 as the most significant bit, so bit n sits at reg_rdata[7-n]. The positions are: break end at bit 1 (0x40), break received at bit 3 (0x10), busy at bit 5 (0x04), transmit done at bit 6 (0x02) and receive at bit 7 (0x01). Bits 0, 2 and 4 always read 0, and writing them sets nothing.
- R2: A write to address 0 clears every event bit whose wdata bit is 1. Zero bits leave their event bits unchanged. Reading address 0 returns the event register at any time.
- R3: Reset (rst_n low) clears the event register and the mask register, and returns both trackers to their idle states.
- R4: A rx_buf_closed strobe sets the receive bit. No other input sets it.
- R5: A cycle with both rx_char_done and rx_zero_char high, taken in BRK_QUIET, sets the break-received bit. Further all-zeros characters in the same break do not set it again, and rx_zero_char without rx_char_done sets nothing.
- R6: In BRK_IN_BREAK, the first rx_idle_bit strobe sets the break-end bit and returns the tracker to BRK_QUIET. Idle bits outside a break set nothing.
- R7: In BSY_ACCEPT, rx_stop_mid with rx_buf_avail low sets the busy bit and enters BSY_STALLED. Further drops while stalled set nothing. rx_buf_avail high returns the tracker to BSY_ACCEPT, and a dropped character never sets the receive bit.
- R8: A tx_last_in_fifo strobe sets the transmit bit.
- R9: Address 1 is an 8-bit read/write mask register. irq is high when any event bit is set and its mask bit is also set.
- R10: irq stays high until every unmasked event bit has been cleared. Clearing the mask also drops irq.
- R11: When a hardware set and a software clear hit the same bit in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_char_done | input | 1 | Receiver finished a character |
| rx_zero_char | input | 1 | Finished character was all zeros (qualified by rx_char_done) |
| rx_idle_bit | input | 1 | Receiver sampled an idle bit |
| rx_stop_mid | input | 1 | Midpoint of the last stop bit |
| rx_buf_avail | input | 1 | Level: an empty receive buffer is available |
| tx_last_in_fifo | input | 1 | Last character of a transmit buffer written to the FIFO |
| rx_buf_closed | input | 1 | Receiver closed a receive buffer |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = event register, 1 = mask register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
Each strobe and each register write is taken at one rising edge. The resulting event bit, mask value and irq level appear right after that edge, because reg_rdata and irq are combinational from the registers. The bench drives each stimulus on a falling edge and lets exactly one rising edge pass. On the next falling edge it drops the strobes, points the address at the event register, and samples one time unit later. Tracker-state cases, such as a second break character or a second dropped character, are checked on that same sample. The expected values already account for the tracker state carried over from earlier rows.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;
    localparam int EVT_W    = 8;
    localparam int IDX_RX   = 0;
    localparam int IDX_TX   = 1;
    localparam int IDX_BSY  = 2;
    localparam int IDX_BRK  = 4;
    localparam int IDX_BRKE = 6;
    localparam logic [EVT_W-1:0] IMPL_MASK =
        EVT_W'((1 << IDX_RX) | (1 << IDX_TX) | (1 << IDX_BSY) |
               (1 << IDX_BRK) | (1 << IDX_BRKE));
    localparam logic ADDR_EVT  = 1'b0;
    localparam logic ADDR_MASK = 1'b1;

    typedef enum logic {BRK_QUIET, BRK_IN_BREAK} brk_state_e;
    typedef enum logic {BSY_ACCEPT, BSY_STALLED} bsy_state_e;
endpackage

// File: rtl/uart_evt_brk.sv
module uart_evt_brk
    import uart_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic char_done,
    input  logic zero_char,
    input  logic idle_bit,
    output logic brk_set,
    output logic brke_set
);
    brk_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BRK_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        brk_set  = 1'b0;
        brke_set = 1'b0;
        unique case (state_q)
            BRK_QUIET: begin
                if (char_done && zero_char) begin
                    brk_set = 1'b1;        // BREAK_START
                    state_d = BRK_IN_BREAK;
                end
            end
            BRK_IN_BREAK: begin
                if (idle_bit) begin
                    brke_set = 1'b1;       // BREAK_END
                    state_d  = BRK_QUIET;
                end
            end
        endcase
    end
endmodule

// File: rtl/uart_evt_bsy.sv
module uart_evt_bsy
    import uart_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_mid,
    input  logic buf_avail,
    output logic bsy_set
);
    bsy_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BSY_ACCEPT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        bsy_set = 1'b0;
        unique case (state_q)
            BSY_ACCEPT: begin
                if (stop_mid && !buf_avail) begin
                    bsy_set = 1'b1;        // DROP
                    state_d = BSY_STALLED;
                end
            end
            BSY_STALLED: begin
                if (buf_avail) state_d = BSY_ACCEPT;  // RESUME
            end
        endcase
    end
endmodule

// File: rtl/uart_evt_regs.sv
module uart_evt_regs
    import uart_evt_pkg::*;
#(
    parameter int W = EVT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         wr,
    input  logic         addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic [W-1:0] evt_q,
    output logic [W-1:0] mask_q,
    output logic         irq
);
    logic [W-1:0] clr_vec;
    logic [W-1:0] evt_d;

    always_comb begin
        clr_vec = (wr && addr == ADDR_EVT) ? wdata : '0;
        // set has priority over clear
        evt_d   = ((evt_q & ~clr_vec) | set_vec) & W'(IMPL_MASK);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q  <= '0;
            mask_q <= '0;
        end else begin
            evt_q <= evt_d;
            if (wr && addr == ADDR_MASK) mask_q <= wdata;
        end
    end

    assign rdata = (addr == ADDR_MASK) ? mask_q : evt_q;
    assign irq   = |(evt_q & mask_q);
endmodule

// File: rtl/uart_evt_top.sv
module uart_evt_top
    import uart_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_char_done,
    input  logic             rx_zero_char,
    input  logic             rx_idle_bit,
    input  logic             rx_stop_mid,
    input  logic             rx_buf_avail,
    input  logic             tx_last_in_fifo,
    input  logic             rx_buf_closed,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [EVT_W-1:0] reg_wdata,
    output logic [EVT_W-1:0] reg_rdata,
    output logic             irq
);
    logic             brk_set, brke_set, bsy_set;
    logic [EVT_W-1:0] set_vec;
    logic [EVT_W-1:0] evt_q, mask_q;

    uart_evt_brk u_brk (
        .clk       (clk),
        .rst_n     (rst_n),
        .char_done (rx_char_done),
        .zero_char (rx_zero_char),
        .idle_bit  (rx_idle_bit),
        .brk_set   (brk_set),
        .brke_set  (brke_set)
    );

    uart_evt_bsy u_bsy (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_mid  (rx_stop_mid),
        .buf_avail (rx_buf_avail),
        .bsy_set   (bsy_set)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[IDX_RX]   = rx_buf_closed;
        set_vec[IDX_TX]   = tx_last_in_fifo;
        set_vec[IDX_BSY]  = bsy_set;
        set_vec[IDX_BRK]  = brk_set;
        set_vec[IDX_BRKE] = brke_set;
    end

    uart_evt_regs #(.W(EVT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .evt_q   (evt_q),
        .mask_q  (mask_q),
        .irq     (irq)
    );
endmodule

// File: rtl/uart_evt_chk.sv
module uart_evt_chk
    import uart_evt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             rx_char_done,
    input logic             rx_zero_char,
    input logic             tx_last_in_fifo,
    input logic             rx_buf_closed,
    input logic             reg_wr,
    input logic             reg_addr,
    input logic [EVT_W-1:0] reg_wdata,
    input logic [EVT_W-1:0] evt,
    input logic [EVT_W-1:0] mask,
    input logic             irq
);
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (evt & ~IMPL_MASK) == '0);

    a_r8_tx_set: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last_in_fifo |=> evt[IDX_TX]);

    a_r4_rx_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt[IDX_RX]) |-> $past(rx_buf_closed));

    a_r5_brk_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt[IDX_BRK]) |-> $past(rx_char_done && rx_zero_char));

    a_r2_clear_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_EVT && reg_wdata[IDX_TX] && !tx_last_in_fifo)
        |=> !evt[IDX_TX]);

    a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt & mask) == '0) |-> !irq);
endmodule

bind uart_evt_top uart_evt_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .rx_char_done    (rx_char_done),
    .rx_zero_char    (rx_zero_char),
    .tx_last_in_fifo (tx_last_in_fifo),
    .rx_buf_closed   (rx_buf_closed),
    .reg_wr          (reg_wr),
    .reg_addr        (reg_addr),
    .reg_wdata       (reg_wdata),
    .evt             (evt_q),
    .mask            (mask_q),
    .irq             (irq)
);

// File: tb/tb_uart_evt_top.sv
`timescale 1ns/1ps
module tb_uart_evt_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_char_done = 0, rx_zero_char = 0, rx_idle_bit = 0;
    logic       rx_stop_mid = 0, rx_buf_avail = 1, tx_last_in_fifo = 0;
    logic       rx_buf_closed = 0, reg_wr = 0, reg_addr = 0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    uart_evt_top dut (.*);

    // row: strobes{char_done,zero,idle,stop_mid,buf_avail,tx_last,buf_closed},
    //      wr, addr, wdata, expected event register, expected irq
    localparam int NV = 26;
    localparam logic [25:0] VEC [NV] = '{
        {7'b0000110, 1'b0, 1'b0, 8'h00, 8'h02, 1'b0}, // R8 tx set
        {7'b0000100, 1'b1, 1'b1, 8'hFF, 8'h02, 1'b1}, // R9 mask all
        {7'b0000101, 1'b0, 1'b0, 8'h00, 8'h03, 1'b1}, // R4 rx set
        {7'b0000100, 1'b1, 1'b0, 8'h02, 8'h01, 1'b1}, // R2 clear tx
        {7'b0000100, 1'b1, 1'b0, 8'h00, 8'h01, 1'b1}, // R2 zero write
        {7'b0100100, 1'b0, 1'b0, 8'h00, 8'h01, 1'b1}, // R5 unqualified zero
        {7'b1100100, 1'b0, 1'b0, 8'h00, 8'h11, 1'b1}, // R5 break start
        {7'b0000100, 1'b1, 1'b0, 8'h10, 8'h01, 1'b1}, // R2 clear brk
        {7'b1100100, 1'b0, 1'b0, 8'h00, 8'h01, 1'b1}, // R5 no repeat
        {7'b0010100, 1'b0, 1'b0, 8'h00, 8'h41, 1'b1}, // R6 break end
        {7'b0010100, 1'b1, 1'b0, 8'h41, 8'h00, 1'b0}, // R6 second idle, R2 multi clear
        {7'b0010100, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0}, // R6 idle outside break
        {7'b1100100, 1'b0, 1'b0, 8'h00, 8'h10, 1'b1}, // R5 new break
        {7'b0010100, 1'b1, 1'b0, 8'h10, 8'h40, 1'b1}, // R6 end + clear brk
        {7'b0000100, 1'b1, 1'b0, 8'h40, 8'h00, 1'b0}, // R10 irq drops
        {7'b1001000, 1'b0, 1'b0, 8'h00, 8'h04, 1'b1}, // R7 drop, no rx
        {7'b0000000, 1'b1, 1'b0, 8'h04, 8'h00, 1'b0}, // R2 clear busy
        {7'b1001000, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0}, // R7 no second
        {7'b0000100, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0}, // R7 resume
        {7'b1001000, 1'b0, 1'b0, 8'h00, 8'h04, 1'b1}, // R7 rearmed
        {7'b0000110, 1'b0, 1'b0, 8'h00, 8'h06, 1'b1}, // R8 tx
        {7'b0000110, 1'b1, 1'b0, 8'h02, 8'h06, 1'b1}, // R11 set wins
        {7'b0000100, 1'b1, 1'b1, 8'h00, 8'h06, 1'b0}, // R10 mask cleared
        {7'b0000100, 1'b1, 1'b1, 8'h02, 8'h06, 1'b1}, // R9 tx only
        {7'b0000100, 1'b1, 1'b0, 8'h02, 8'h04, 1'b0}, // R10 busy masked
        {7'b0000100, 1'b1, 1'b0, 8'hFF, 8'h00, 1'b0}  // R1 reserved stay 0
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rx_char_done = 0; rx_zero_char = 0; rx_idle_bit = 0; rx_stop_mid = 0;
        tx_last_in_fifo = 0; rx_buf_closed = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    endtask

    task automatic step_check(input string req, input logic [7:0] exp_evt, input logic exp_irq);
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        #1;
        check(req, reg_rdata, exp_evt);
        check(req, {7'd0, irq}, {7'd0, exp_irq});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R3 reset state
        check("R3 evt", reg_rdata, 8'h00);
        check("R3 irq", {7'd0, irq}, 8'h00);
        reg_addr = 1'b1; #1;
        check("R3 mask", reg_rdata, 8'h00);
        reg_addr = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {rx_char_done, rx_zero_char, rx_idle_bit, rx_stop_mid, rx_buf_avail,
             tx_last_in_fifo, rx_buf_closed} = VEC[i][25:19];
            reg_wr    = VEC[i][18];
            reg_addr  = VEC[i][17];
            reg_wdata = VEC[i][16:9];
            step_check($sformatf("row%0d", i), VEC[i][8:1], VEC[i][0]);
        end

        // R9 mask readback
        @(negedge clk);
        reg_wr = 1; reg_addr = 1; reg_wdata = 8'hA5;
        @(posedge clk); @(negedge clk);
        idle_inputs(); reg_addr = 1; #1;
        check("R9 mask readback", reg_rdata, 8'hA5);
        reg_addr = 0;

        // R3 mid-run reset clears tracker: enter break, reset, new zero char must set brk
        @(negedge clk);
        rx_char_done = 1; rx_zero_char = 1; tx_last_in_fifo = 1;
        step_check("R3 pre-reset", 8'h12, 1'b0);
        rst_n = 0;
        @(posedge clk); @(negedge clk);
        rst_n = 1; #1;
        check("R3 evt after reset", reg_rdata, 8'h00);
        reg_addr = 1; #1;
        check("R3 mask after reset", reg_rdata, 8'h00);
        reg_addr = 0;
        @(negedge clk);
        rx_char_done = 1; rx_zero_char = 1;
        step_check("R3 R5 tracker reset", 8'h10, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule